// File: doc/BRIEF.md
# Carrier Detect Hysteresis Qualifier

This block takes a per-sample "in-band energy present" flag from an FSK receive front end. It produces a debounced, active-low carrier-detect signal. The flag must stay high for a qualification window before carrier-detect goes low. After that, carrier-detect stays low through short gaps in the energy. It returns high only after the energy has been absent for a full release window. The block does not tell voice from modem tones. Any in-band energy that persists long enough qualifies, whether it comes from the 1200/2200 Hz pair or from the 1300/2100 Hz pair.

A second output, `data_gate`, is high exactly while carrier is detected. Downstream logic uses it to pass the demodulated serial bit stream, and to hold that stream at logic high while it is low. When `pwr_down` is high, carrier-detect reads as inactive (high, as a released line with a pull-up would read) and the gate is closed. On leaving power-down the block restarts from idle with its timers cleared.

Both windows are parameters counted in master clock cycles. The defaults are about 10 ms to assert and 8 ms to release at a 3.579545 MHz clock. Both must be at least 2.

Top module: `cd_hyst_qual`

## Requirements
- R1: While `rst_n` is low, `cd_n` is 1 and `data_gate` is 0.
- R2: `cd_n` goes to 0 after the rising clock edge at which `energy_in` has been sampled 1 on QUAL_CYCLES consecutive edges. After only QUAL_CYCLES-1 such edges it is still 1.
- R3: A single 0 sample on `energy_in` before qualification completes restarts the count. A full fresh run of QUAL_CYCLES ones is then needed.
- R4: Once `cd_n` is 0, any run of fewer than HOLD_CYCLES consecutive 0 samples leaves `cd_n` at 0.
- R5: `cd_n` returns to 1 after the edge at which `energy_in` has been sampled 0 on HOLD_CYCLES consecutive edges.
- R6: A 1 sample during a dropout resumes detection without re-qualifying. A later release again needs a full run of HOLD_CYCLES zeros.
- R7: `data_gate` is 1 exactly when `cd_n` is 0.
- R8: While `pwr_down` is 1, `cd_n` is 1 and `data_gate` is 0, starting in the same cycle. After `pwr_down` falls, a full run of QUAL_CYCLES ones is needed before `cd_n` goes to 0.
- R9: After a release, detecting carrier again needs a full run of QUAL_CYCLES ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all samples are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down request, active high |
| energy_in | input | 1 | Raw per-sample in-band energy indication |
| cd_n | output | 1 | Carrier detect, active low |
| data_gate | output | 1 | High while serial data may pass downstream |

## Verification
A state or counter fault in this block shows up at `cd_n` as an edge in the wrong cycle. Qualifying early or late moves the falling edge off the QUAL_CYCLES-th consecutive high sample. A hold counter that is not restarted moves the release away from the HOLD_CYCLES-th consecutive low sample. A power-down that fails to clear the counters shortens the next qualification. Each of these faults appears within one window length of the stimulus that exposes it. The bench therefore compares both outputs after every clock edge against a run-length model, so any fault is caught in the first cycle it appears.

// File: rtl/cd_hyst_qual.sv
module cd_hyst_qual #(
  parameter int unsigned QUAL_CYCLES = 35795,
  parameter int unsigned HOLD_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic energy_in,
  output logic cd_n,
  output logic data_gate
);

  localparam int unsigned MAXC = (QUAL_CYCLES > HOLD_CYCLES) ? QUAL_CYCLES : HOLD_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_QUAL, S_ACT, S_HOLD} st_t;

  st_t           state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    unique case (state)
      S_IDLE: if (energy_in) begin
        state_nx = S_QUAL;
        cnt_nx   = CW'(1);
      end
      S_QUAL: begin
        if (!energy_in) begin
          state_nx = S_IDLE;
          cnt_nx   = '0;
        end else if (cnt == QUAL_LAST) begin
          state_nx = S_ACT;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + CW'(1);
        end
      end
      S_ACT: if (!energy_in) begin
        state_nx = S_HOLD;
        cnt_nx   = CW'(1);
      end
      S_HOLD: begin
        if (energy_in) begin
          state_nx = S_ACT;
          cnt_nx   = '0;
        end else if (cnt == HOLD_LAST) begin
          state_nx = S_IDLE;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + CW'(1);
        end
      end
      default: begin
        state_nx = S_IDLE;
        cnt_nx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (pwr_down) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  wire detected = (state == S_ACT) || (state == S_HOLD);

  assign cd_n      = pwr_down | ~detected;
  assign data_gate = ~pwr_down & detected;

  // R8
  pd_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (cd_n && !data_gate));

  // R8
  pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (state == S_IDLE && cnt == '0));

  // R2
  assert_only_from_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && $past(!pwr_down) && $fell(cd_n)) |-> ($past(state) == S_QUAL && $past(energy_in)));

  // R5
  release_only_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && $past(!pwr_down) && $rose(cd_n)) |-> ($past(state) == S_HOLD && !$past(energy_in)));

  // R3
  qual_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_QUAL) |-> (cnt != '0 && cnt <= QUAL_LAST));

  // R6
  hold_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && energy_in && !pwr_down) |=> (state == S_ACT && !cd_n));

  // R7
  gate_matches_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_gate == !cd_n);

endmodule

// File: tb/test_cd_hyst_qual.sv
module test_cd_hyst_qual;
  localparam int Q = 6;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic energy_in = 1'b0;
  logic cd_n, data_gate;

  always #4 clk = ~clk;

  cd_hyst_qual #(.QUAL_CYCLES(Q), .HOLD_CYCLES(H)) i_cd_hyst_qual (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .energy_in(energy_in),
    .cd_n(cd_n), .data_gate(data_gate));

  typedef struct { logic cd; logic gate; string tag; } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  bit m_det = 1'b0;
  int m_hi = 0, m_lo = 0;

  task automatic step(input logic e, input logic pd, input string tag);
    exp_t x;
    @(negedge clk);
    energy_in = e;
    pwr_down  = pd;
    if (pd) begin
      m_det = 1'b0; m_hi = 0; m_lo = 0;
    end else if (!m_det) begin
      if (e) begin
        m_hi++;
        if (m_hi == Q) begin m_det = 1'b1; m_lo = 0; end
      end else m_hi = 0;
    end else begin
      if (e) m_lo = 0;
      else begin
        m_lo++;
        if (m_lo == H) begin m_det = 1'b0; m_hi = 0; end
      end
    end
    x.cd = pd | ~m_det;
    x.gate = ~pd & m_det;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic run(input logic e, input int n, input string tag);
    for (int i = 0; i < n; i++) step(e, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    exp_t x;
    #2;
    if (q.size() > 0) begin
      x = q.pop_front();
      n_cmp++;
      if (cd_n !== x.cd) begin
        n_bad++;
        $display("FAIL %s cd_n actual=%b expected=%b", x.tag, cd_n, x.cd);
      end
      n_cmp++;
      if (data_gate !== x.gate) begin
        n_bad++;
        $display("FAIL %s/R7 data_gate actual=%b expected=%b", x.tag, data_gate, x.gate);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (cd_n !== 1'b1 || data_gate !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%b%b expected=10", cd_n, data_gate);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run(1'b0, 2, "R1");
    run(1'b1, Q-1, "R2");
    run(1'b0, 1, "R3");
    for (int i = 0; i < 4; i++) begin
      run(1'b1, 1, "R3");
      run(1'b0, 1, "R3");
    end
    run(1'b1, Q-2, "R3");
    run(1'b0, 1, "R3");
    run(1'b1, Q, "R2");
    run(1'b1, 3, "R2");
    run(1'b0, H-1, "R4");
    run(1'b1, 1, "R4");
    run(1'b0, 1, "R4");
    run(1'b1, 2, "R4");
    run(1'b0, H-1, "R6");
    run(1'b1, 1, "R6");
    run(1'b0, H-1, "R6");
    run(1'b1, 1, "R6");
    run(1'b0, H, "R5");
    run(1'b0, 3, "R5");
    run(1'b1, Q-1, "R9");
    run(1'b0, 1, "R9");
    run(1'b1, Q+2, "R9");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R8");
    run(1'b1, Q-1, "R8");
    run(1'b1, 2, "R8");
    run(1'b0, 2, "R8");
    step(1'b0, 1'b1, "R8");
    run(1'b1, Q+1, "R8");
    run(1'b0, H+1, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule